// File: doc/BRIEF.md
# Sixteen-Bit Bit-Slice Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for two 16-bit operands. It is built from one one-bit slice, replicated across the word. A 3-bit operation code enters a small decoder. The decoder expands the code into a per-slice control word with these fields: operand-A inversion, operand-B suppression, the initial carry, an arithmetic marker and a result-function select. Every slice receives the same control word.

Each slice returns a result bit and its local generate and propagate terms. A separate carry network turns those terms into the carry for every slice. A parameter chooses the carry network: a plain ripple chain, or 4-bit lookahead groups chained by group generate and propagate. Both choices give the same outputs.

The unit also drives a carry-out flag and an all-zero flag. Subtraction uses the reversed order: it computes B minus A, formed as B + ~A + 1.

Top module: `alu16_bitslice`

## Requirements
- R1: Code 3'd0 drives A + B (mod 2^16) on the result, and the carry-out equals bit 16 of the 17-bit sum.
- R2: Code 3'd6 drives B − A (mod 2^16), and the carry-out is 1 exactly when B ≥ A as unsigned numbers.
- R3: Code 3'd2 drives A + 1 (mod 2^16), and the carry-out is 1 only when A is 16'hFFFF. B has no effect.
- R4: Code 3'd3 drives A unchanged, and the carry-out is 0. B has no effect.
- R5: Code 3'd1 drives the bitwise XOR of A and B, and the carry-out is 0.
- R6: Code 3'd5 drives the bitwise XNOR of A and B, and the carry-out is 0.
- R7: Codes 3'd4 and 3'd7 drive an all-zero result and a carry-out of 0, whatever the operands are.
- R8: The zero flag is 1 exactly when all 16 result bits are 0, for every code.
- R9: With the lookahead carry network and with the ripple network, the unit gives identical result, carry-out and zero flag for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| res_o | output | 16 | Result word |
| cout_o | output | 1 | Carry from the top slice for arithmetic codes, else 0 |
| zero_o | output | 1 | High when the result word is all zeros |

## Verification
Every output is combinational, so each result is due in the same cycle its inputs change, with no register on the path. The bench applies the operands and code just after a rising clock edge. It compares the outputs at the following falling edge, half a period later, after the logic has settled and before the next stimulus. The bench keeps a ripple-carry and a lookahead-carry instance side by side on the same inputs. It checks both against a reference built from the requirements, and it checks them against each other.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  // External operation codes. The values are the interface contract.
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_XOR  = 3'd1,
    OP_INC  = 3'd2,
    OP_PASS = 3'd3,
    OP_NIL4 = 3'd4,
    OP_XNOR = 3'd5,
    OP_RSUB = 3'd6,
    OP_NIL7 = 3'd7
  } alu_op_e;

  // Result function chosen inside each slice.
  typedef enum logic [2:0] {
    FN_SUM  = 3'd0,
    FN_XOR  = 3'd1,
    FN_XNOR = 3'd2,
    FN_PASS = 3'd3,
    FN_ZERO = 3'd4
  } slice_fn_e;

  // Control word shared by every slice.
  typedef struct packed {
    logic      inv_a;   // feed ~a into the adder path
    logic      kill_b;  // feed 0 instead of b into the adder path
    logic      cin;     // carry into slice 0
    logic      arith;   // carry-out is meaningful
    slice_fn_e fn;
  } slice_ctrl_t;

endpackage

// File: rtl/alu16_opdec.sv
module alu16_opdec
  import alu16_pkg::*;
(
  input  logic [2:0]  op_i,
  output slice_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o = '{inv_a: 1'b0, kill_b: 1'b0, cin: 1'b0, arith: 1'b0, fn: FN_ZERO};
    case (alu_op_e'(op_i))
      OP_ADD:  begin ctrl_o.fn = FN_SUM;  ctrl_o.arith = 1'b1; end
      OP_RSUB: begin ctrl_o.fn = FN_SUM;  ctrl_o.arith = 1'b1;
                     ctrl_o.inv_a = 1'b1; ctrl_o.cin = 1'b1; end
      OP_INC:  begin ctrl_o.fn = FN_SUM;  ctrl_o.arith = 1'b1;
                     ctrl_o.kill_b = 1'b1; ctrl_o.cin = 1'b1; end
      OP_PASS: ctrl_o.fn = FN_PASS;
      OP_XOR:  ctrl_o.fn = FN_XOR;
      OP_XNOR: ctrl_o.fn = FN_XNOR;
      default: ctrl_o.fn = FN_ZERO;
    endcase
  end

endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
  import alu16_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        c_i,
  input  slice_ctrl_t ctrl_i,
  output logic        r_o,
  output logic        g_o,
  output logic        p_o
);

  logic aa, bb;

  always_comb begin
    aa  = a_i ^ ctrl_i.inv_a;
    bb  = b_i & ~ctrl_i.kill_b;
    g_o = aa & bb;
    p_o = aa ^ bb;
    case (ctrl_i.fn)
      FN_SUM:  r_o = p_o ^ c_i;
      FN_XOR:  r_o = a_i ^ b_i;
      FN_XNOR: r_o = ~(a_i ^ b_i);
      FN_PASS: r_o = a_i;
      default: r_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu16_carry_net.sv
// Width must be a multiple of GRP when LOOKAHEAD is set.
module alu16_carry_net #(
  parameter int W         = 16,
  parameter bit LOOKAHEAD = 1'b1,
  parameter int GRP       = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         c0_i,
  output logic [W:0]   c_o
);

  localparam int NG = W / GRP;

  assign c_o[0] = c0_i;

  if (LOOKAHEAD) begin : g_cla
    logic [NG:0] cg;
    assign cg[0] = c0_i;

    for (genvar n = 0; n < NG; n++) begin : g_grp
      localparam int BASE = n * GRP;
      logic [GRP:1] gk, pk;

      // Prefix generate/propagate from the group base up to each bit.
      always_comb begin
        logic ga, pa;
        ga = 1'b0;
        pa = 1'b1;
        for (int k = 0; k < GRP; k++) begin
          ga = g_i[BASE+k] | (p_i[BASE+k] & ga);
          pa = pa & p_i[BASE+k];
          gk[k+1] = ga;
          pk[k+1] = pa;
        end
      end

      for (genvar k = 1; k < GRP; k++) begin : g_in
        assign c_o[BASE+k] = gk[k] | (pk[k] & cg[n]);
      end
      assign cg[n+1]          = gk[GRP] | (pk[GRP] & cg[n]);
      assign c_o[BASE+GRP]    = cg[n+1];
    end
  end else begin : g_rip
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign c_o[i+1] = g_i[i] | (p_i[i] & c_o[i]);
    end
  end

endmodule

// File: rtl/alu16_bitslice.sv
module alu16_bitslice
  import alu16_pkg::*;
#(
  parameter int W         = 16,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         zero_o
);

  slice_ctrl_t  ctrl;
  logic [W-1:0] gen, prop;
  logic [W:0]   carry;

  alu16_opdec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu16_slice u_sl (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .c_i    (carry[i]),
      .ctrl_i (ctrl),
      .r_o    (res_o[i]),
      .g_o    (gen[i]),
      .p_o    (prop[i])
    );
  end

  alu16_carry_net #(.W(W), .LOOKAHEAD(LOOKAHEAD), .GRP(4)) u_cn (
    .g_i  (gen),
    .p_i  (prop),
    .c0_i (ctrl.cin),
    .c_o  (carry)
  );

  assign cout_o = ctrl.arith & carry[W];
  assign zero_o = ~|res_o;

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int W = 16
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic         zero_o
);

  logic [W:0] wide_sum, wide_sub, wide_inc;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    wide_sub = {1'b0, b_i} + {1'b0, ~a_i} + {{W{1'b0}}, 1'b1};
    wide_inc = {1'b0, a_i} + {{W{1'b0}}, 1'b1};
    case (op_i)
      3'd0: p_add_r1:  assert ({cout_o, res_o} == wide_sum) else $error("R1 add mismatch");
      3'd6: p_rsub_r2: assert (res_o == W'(b_i - a_i) && cout_o == (b_i >= a_i))
                       else $error("R2 reverse subtract mismatch");
      3'd2: p_inc_r3:  assert ({cout_o, res_o} == wide_inc) else $error("R3 increment mismatch");
      3'd3: p_pass_r4: assert (res_o == a_i && !cout_o) else $error("R4 pass mismatch");
      3'd1: p_xor_r5:  assert (res_o == (a_i ^ b_i) && !cout_o) else $error("R5 xor mismatch");
      3'd5: p_xnor_r6: assert (res_o == ~(a_i ^ b_i) && !cout_o) else $error("R6 xnor mismatch");
      default: p_nil_r7: assert (res_o == '0 && !cout_o) else $error("R7 unused code mismatch");
    endcase
    p_zero_r8: assert (zero_o == (res_o == '0)) else $error("R8 zero flag mismatch");
  end

  // wide_sub is kept for a carry cross-check on the reverse subtract.
  always_comb begin
    if (op_i == 3'd6) begin
      p_rsub_c_r2: assert (cout_o == wide_sub[W]) else $error("R2 carry mismatch");
    end
  end

endmodule

bind alu16_bitslice alu16_checker #(.W(W)) u_chk (
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .cout_o (cout_o),
  .zero_o (zero_o)
);

// File: tb/sim_alu16_bitslice.sv
`timescale 1ns/1ps
module sim_alu16_bitslice;

  localparam int W = 16;

  logic         clk;
  logic [2:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res0, res1;
  logic         co0, co1, z0, z1;
  int           n_run, n_fail;
  logic [31:0]  rng;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  alu16_bitslice #(.W(W), .LOOKAHEAD(1'b1)) u0 (
    .op_i(op), .a_i(a), .b_i(b), .res_o(res0), .cout_o(co0), .zero_o(z0));
  alu16_bitslice #(.W(W), .LOOKAHEAD(1'b0)) u1 (
    .op_i(op), .a_i(a), .b_i(b), .res_o(res1), .cout_o(co1), .zero_o(z1));

  // Reference from the requirements: returns {zero, carry, result}.
  function automatic logic [W+1:0] ref_model(input logic [2:0] o,
                                             input logic [W-1:0] x, y);
    logic [W:0] t;
    case (o)
      3'd0: t = {1'b0, x} + {1'b0, y};
      3'd6: t = {(y >= x), W'(y - x)};
      3'd2: t = {(x == '1), W'(x + 1'b1)};
      3'd3: t = {1'b0, x};
      3'd1: t = {1'b0, x ^ y};
      3'd5: t = {1'b0, ~(x ^ y)};
      default: t = '0;
    endcase
    return {(t[W-1:0] == '0), t};
  endfunction

  task automatic check(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
    end
  endtask

  // Drive just after a rising edge, compare half a period later.
  task automatic apply(input string tag, input logic [2:0] o,
                       input logic [W-1:0] x, y);
    @(posedge clk); #1;
    op = o; a = x; b = y;
    @(negedge clk);
    check(tag, {z0, co0, res0}, ref_model(o, x, y));
  endtask

  task automatic t_start;
    @(negedge clk);
    check("R8 start", {z0, co0, res0}, {1'b1, 1'b0, {W{1'b0}}});
  endtask

  task automatic t_add;
    apply("R1 add small", 3'd0, 16'h1234, 16'h0101);
    apply("R1 add carry", 3'd0, 16'hFFFF, 16'h0001);
    apply("R1 add both top", 3'd0, 16'h8000, 16'h8001);
  endtask

  task automatic t_rsub;
    apply("R2 sub b>a", 3'd6, 16'h0003, 16'h0010);
    apply("R2 sub b<a", 3'd6, 16'h0010, 16'h0003);
    apply("R2 sub equal", 3'd6, 16'hABCD, 16'hABCD);
    apply("R2 sub zero a", 3'd6, 16'h0000, 16'h7777);
  endtask

  task automatic t_inc;
    apply("R3 inc", 3'd2, 16'h00FF, 16'hFFFF);
    apply("R3 inc wrap", 3'd2, 16'hFFFF, 16'h1234);
  endtask

  task automatic t_pass;
    apply("R4 pass", 3'd3, 16'hC3A5, 16'hFFFF);
    apply("R4 pass zero", 3'd3, 16'h0000, 16'h5A5A);
  endtask

  task automatic t_logic;
    apply("R5 xor", 3'd1, 16'hF0F0, 16'hFF00);
    apply("R5 xor same", 3'd1, 16'h1357, 16'h1357);
    apply("R6 xnor", 3'd5, 16'hF0F0, 16'hFF00);
    apply("R6 xnor opp", 3'd5, 16'hAAAA, 16'h5555);
  endtask

  task automatic t_unused;
    apply("R7 code4", 3'd4, 16'hFFFF, 16'hFFFF);
    apply("R7 code7", 3'd7, 16'h8001, 16'h7FFE);
  endtask

  task automatic t_zero;
    apply("R8 add to zero", 3'd0, 16'h8000, 16'h8000);
    apply("R8 nonzero", 3'd1, 16'h0001, 16'h0000);
  endtask

  task automatic t_networks;
    rng = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      @(posedge clk); #1;
      op = rng[2:0]; a = rng[31:16]; b = rng[18:3];
      @(negedge clk);
      check("R9 lookahead vs ref", {z0, co0, res0}, ref_model(op, a, b));
      check("R9 ripple vs lookahead", {z1, co1, res1}, {z0, co0, res0});
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    op = 3'd0; a = '0; b = '0;
    t_start;
    t_add;
    t_rsub;
    t_inc;
    t_pass;
    t_logic;
    t_unused;
    t_zero;
    t_networks;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule